// File: doc/BRIEF.md
# SPI Byte Master with Clock Mode Control

This block is a single-byte SPI master driven through a three-register host port. The host sets the clock idle level, the sampling phase and the bit rate in a control register, then writes a byte into the data register. That write starts a full-duplex exchange of eight bits on `sck`, `mosi` and `miso`, most significant bit first. When the eighth bit has been shifted, the clock stops at its idle level, a completion flag rises, and the byte gathered from `miso` is copied into a receive buffer. The buffer stays readable while the next byte is going out.

Writing the data register while a byte is still shifting does not disturb the exchange. It raises a collision flag. Both flags clear when the host reads the status register while a flag is set and then accesses the data register. A guard option lets an external device take over the bus: when the guard is enabled and `ss_in` is pulled low, the master drops out of operation. The host drives the slave-select line to the target through a port of its own, outside this block.

Register map (`reg_sel`): 0 = control (read/write), 1 = status (read only), 2 = data (write starts an exchange, read returns the receive buffer), 3 = reads as zero. Control bits: [0] enable, [1] clock idle level (CPOL), [2] sample phase (CPHA), [4:3] rate select, [5] double speed, [6] select guard. Status bits: [0] done, [1] collision, [2] busy.

Top module: `spi_host_ctrl`

## Requirements
- R1: Each exchange moves exactly 8 bits in both directions. Afterwards the slave holds the byte written to data register 2, and a read of data register 2 returns the byte the slave sent.
- R2: Both `mosi` and `miso` carry the most significant bit first.
- R3: While no exchange runs, `sck` sits at control bit [1] (CPOL). The first transition of an exchange moves away from that level.
- R4: With control bit [2] (CPHA) = 0, bits are sampled on leading edges and `mosi` changes on trailing edges. With CPHA = 1, bits are sampled on trailing edges and `mosi` changes on leading edges. `mosi` never changes across a sampling edge.
- R5: Control bits [4:3] = 0,1,2,3 give an `sck` period of 4, 16, 64 and 128 system clocks. Control bit [5] halves it to 2, 8, 32 and 64. Each `sck` half period lasts exactly half the period, counted from the write that starts the exchange.
- R6: A write to data register 2, with enable (control bit [0]) set and no exchange running, sets busy (status bit [2]) in the next cycle. After the 16th `sck` transition, busy clears and done (status bit [0]) sets in the same cycle.
- R7: A write to data register 2 during an exchange sets collision (status bit [1]) and leaves the running exchange and its data unchanged.
- R8: Done and collision clear when a status read finds either of them set and is followed by a read or write of data register 2. An access to data register 2 without such a preceding status read leaves both flags set.
- R9: With the guard (control bit [6]) and enable both set, a low on `ss_in` clears enable, sets done, and stops any exchange with `sck` returned to its idle level, within 3 cycles (2-stage synchronizer). With the guard clear, `ss_in` has no effect.
- R10: A write to data register 2 while enable is clear starts nothing: busy stays 0 and `sck` stays idle.
- R11: The receive buffer changes only when an exchange completes, so the previous byte stays readable while the next one shifts.
- R12: After reset, the control register, the flags and the receive buffer read as zero, and `sck` and `mosi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; carries the side effects of flag clearing |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| sck | output | 1 | Serial clock to the slave |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_in | input | 1 | External select sense; low aborts master operation when guarded |

## Verification
The in-line assertions check several cycle-level rules on every cycle: the idle clock level, that `mosi` holds across each sampling edge, that the collision and abort flags take effect one cycle after their cause, that done follows the last edge, and that the receive buffer only moves at completion. The wider behaviours can only be shown by the bench's scenarios. These are the bit order and full-duplex byte exchange against a slave model in all four clock modes and several rates, the exact edge timing for each divider setting, the status read then data access order that clears the flags, buffer contents during a following exchange, and the guard abort compared with an ignored `ss_in`.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // packed MSB first: bit6 guard .. bit0 enable
  typedef struct packed {
    logic       ss_guard;
    logic       dbl;
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int HALF_W = 7;

  // system clocks per sck half period
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate, input logic dbl);
    logic [HALF_W-1:0] h;
    case (rate)
      2'd0:    h = HALF_W'(2);
      2'd1:    h = HALF_W'(8);
      2'd2:    h = HALF_W'(32);
      default: h = HALF_W'(64);
    endcase
    return dbl ? (h >> 1) : h;
  endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = HALF_W,
  localparam int EDGES = 2 * DATA_W,
  localparam int EW    = $clog2(EDGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             cpol,
  input  logic [1:0]       rate,
  input  logic             dbl,
  output logic             sck,
  output logic             busy,
  output logic             edge_pulse,
  output logic [EW-1:0]    edge_idx,
  output logic             last_edge
);

  logic             busy_q, busy_n;
  logic             sck_q, sck_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [EW-1:0]    edge_q, edge_n;
  logic [DIV_W-1:0] half_m1;
  logic             tick;

  assign half_m1 = DIV_W'(half_period(rate, dbl)) - DIV_W'(1);
  assign tick    = busy_q && (div_q == half_m1);

  always_comb begin
    busy_n = busy_q;
    sck_n  = sck_q;
    div_n  = div_q;
    edge_n = edge_q;
    if (abort) begin
      busy_n = 1'b0;
      sck_n  = cpol;
      div_n  = '0;
      edge_n = '0;
    end else if (start) begin
      busy_n = 1'b1;
      sck_n  = cpol;
      div_n  = '0;
      edge_n = '0;
    end else if (busy_q) begin
      if (tick) begin
        div_n = '0;
        sck_n = ~sck_q;
        if (edge_q == EW'(EDGES - 1)) begin
          busy_n = 1'b0;
          edge_n = '0;
        end else begin
          edge_n = edge_q + EW'(1);
        end
      end else begin
        div_n = div_q + DIV_W'(1);
      end
    end else begin
      sck_n = cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
    end else begin
      busy_q <= busy_n;
      sck_q  <= sck_n;
      div_q  <= div_n;
      edge_q <= edge_n;
    end
  end

  assign sck        = sck_q;
  assign busy       = busy_q;
  assign edge_pulse = tick && !abort;
  assign edge_idx   = edge_q;
  assign last_edge  = tick && !abort && (edge_q == EW'(EDGES - 1));

  // R3: clock returns to / rests at idle level when no exchange runs
  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> (sck_q == $past(cpol)));

  // R6: a normal end of an exchange only after the final edge
  assert_end_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$past(abort)) |-> ($past(edge_q) == EW'(EDGES - 1)));

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 8,
  localparam int EW    = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] load_data,
  input  logic              edge_pulse,
  input  logic [EW-1:0]     edge_idx,
  input  logic              last_edge,
  input  logic              cpha,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_buf
);

  logic [DATA_W-1:0] tx_q, tx_n;
  logic [DATA_W-1:0] rx_q, rx_n;
  logic [DATA_W-1:0] buf_q, buf_n;
  logic [DATA_W-1:0] rx_shifted;
  logic              lead, trail, first_edge, sample, shift;

  assign lead       = edge_pulse && !edge_idx[0];
  assign trail      = edge_pulse &&  edge_idx[0];
  assign first_edge = (edge_idx == '0);
  assign sample     = cpha ? trail : lead;
  assign shift      = cpha ? (lead && !first_edge) : trail;
  assign rx_shifted = {rx_q[DATA_W-2:0], miso};

  always_comb begin
    tx_n  = tx_q;
    rx_n  = rx_q;
    buf_n = buf_q;
    if (start) begin
      tx_n = load_data;
      rx_n = '0;
    end else begin
      if (shift)  tx_n = {tx_q[DATA_W-2:0], 1'b0};
      if (sample) rx_n = rx_shifted;
    end
    if (last_edge) buf_n = sample ? rx_shifted : rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      buf_q <= '0;
    end else begin
      tx_q  <= tx_n;
      rx_q  <= rx_n;
      buf_q <= buf_n;
    end
  end

  assign mosi   = tx_q[DATA_W-1];
  assign rx_buf = buf_q;

  // R4: outgoing bit holds across every sampling edge
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> $stable(mosi));

  // R11: receive buffer only moves when an exchange completes
  assert_buf_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !last_edge |=> $stable(buf_q));

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              xfer_end,
  input  logic [DATA_W-1:0] rx_buf,
  input  logic              ss_in,
  output ctrl_t             ctrl,
  output logic              start,
  output logic              abort,
  output logic [DATA_W-1:0] rdata
);

  reg_sel_e          sel_e;
  ctrl_t             ctrl_q, ctrl_n;
  logic              done_q, done_n;
  logic              wcol_q, wcol_n;
  logic              arm_q, arm_n;
  logic [SYNC_W-1:0] ss_pipe;
  logic              ss_sync;
  logic              data_wr, data_acc, stat_rd, ctrl_we, col_set;

  assign sel_e    = reg_sel_e'(sel);
  assign data_wr  = (sel_e == SEL_DATA) && wr;
  assign data_acc = (sel_e == SEL_DATA) && (wr || rd);
  assign stat_rd  = (sel_e == SEL_STAT) && rd;
  assign ctrl_we  = (sel_e == SEL_CTRL) && wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_pipe <= '1;
    else        ss_pipe <= {ss_pipe[SYNC_W-2:0], ss_in};
  end
  assign ss_sync = ss_pipe[SYNC_W-1];

  assign abort   = ctrl_q.ss_guard && ctrl_q.en && !ss_sync;
  assign start   = data_wr && ctrl_q.en && !busy && !abort;
  assign col_set = data_wr && busy;

  always_comb begin
    ctrl_n = ctrl_q;
    done_n = done_q;
    wcol_n = wcol_q;
    arm_n  = arm_q;
    if (ctrl_we) ctrl_n = wdata[CTRL_W-1:0];
    if (abort)   ctrl_n.en = 1'b0;
    if (data_acc) begin
      arm_n = 1'b0;
      if (arm_q) begin
        done_n = 1'b0;
        wcol_n = 1'b0;
      end
    end
    if (stat_rd && (done_q || wcol_q)) arm_n = 1'b1;
    if (xfer_end || abort) done_n = 1'b1;
    if (col_set)           wcol_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      wcol_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      done_q <= done_n;
      wcol_q <= wcol_n;
      arm_q  <= arm_n;
    end
  end

  always_comb begin
    case (sel_e)
      SEL_CTRL: rdata = DATA_W'(ctrl_q);
      SEL_STAT: rdata = DATA_W'({busy, wcol_q, done_q});
      SEL_DATA: rdata = rx_buf;
      default:  rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;

  // R7: a write into a running exchange raises the collision flag
  assert_col_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> wcol_q);

  // R7: that write does not end the running exchange
  assert_col_keeps_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy && !xfer_end && !abort) |=> busy);

  // R9: guarded select low drops enable and flags completion
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!ctrl_q.en && done_q));

  // R6: completion flag follows the final edge
  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> done_q);

  // R10: data write while disabled starts nothing
  assert_disabled_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ctrl_q.en && !busy) |=> !busy);

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_W = 2,
  parameter int RST_W  = 2,
  localparam int EW    = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  input  logic              ss_in
);

  logic [RST_W-1:0]  rst_pipe;
  logic              rst_sync_n;
  ctrl_t             ctrl;
  logic              start, abort, busy, edge_pulse, last_edge;
  logic [EW-1:0]     edge_idx;
  logic [DATA_W-1:0] rx_buf;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_W-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_W-1];

  spi_host_regs #(.DATA_W(DATA_W), .SYNC_W(SYNC_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sel      (reg_sel),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .wdata    (reg_wdata),
    .busy     (busy),
    .xfer_end (last_edge),
    .rx_buf   (rx_buf),
    .ss_in    (ss_in),
    .ctrl     (ctrl),
    .start    (start),
    .abort    (abort),
    .rdata    (reg_rdata)
  );

  spi_sck_gen #(.DATA_W(DATA_W)) u_sck (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .abort      (abort),
    .cpol       (ctrl.cpol),
    .rate       (ctrl.rate),
    .dbl        (ctrl.dbl),
    .sck        (sck),
    .busy       (busy),
    .edge_pulse (edge_pulse),
    .edge_idx   (edge_idx),
    .last_edge  (last_edge)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .load_data  (reg_wdata),
    .edge_pulse (edge_pulse),
    .edge_idx   (edge_idx),
    .last_edge  (last_edge),
    .cpha       (ctrl.cpha),
    .miso       (miso),
    .mosi       (mosi),
    .rx_buf     (rx_buf)
  );

endmodule

// File: tb/spi_host_ctrl_test.sv
`timescale 1ns/1ps
module spi_host_ctrl_test;

  localparam logic [1:0] S_CTRL = 2'd0, S_STAT = 2'd1, S_DATA = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = S_STAT;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sck, mosi;
  logic       miso;
  logic       ss_in = 1'b1;

  int checks = 0, errors = 0;

  // reference model state
  bit   pending = 0, active = 0, finished = 0;
  int   m, seen, b_h, tr_err, tr_act, tr_exp;
  bit   b_cpol, b_cpha, sck_prev;
  logic [7:0] slv_tx, slv_rx;

  always #2.5 clk = ~clk;

  spi_host_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_in(ss_in)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic access(input logic [1:0] sel, input bit wr, input bit rd,
                        input logic [7:0] wd, output logic [7:0] rd_val);
    @(negedge clk);
    reg_sel = sel; reg_wr = wr; reg_rd = rd; reg_wdata = wd;
    #1 rd_val = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = S_STAT;
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] wd);
    logic [7:0] dummy;
    access(sel, 1'b1, 1'b0, wd, dummy);
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [7:0] v);
    access(sel, 1'b0, 1'b1, 8'h00, v);
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b0; reg_rd = 1'b0;
    #1 v = reg_rdata;
  endtask

  // data write that starts an exchange tracked by the model
  task automatic data_start(input logic [7:0] tx);
    @(negedge clk);
    reg_sel = S_DATA; reg_wr = 1'b1; reg_rd = 1'b0; reg_wdata = tx;
    @(posedge clk);
    pending = 1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = S_STAT;
  endtask

  function automatic int half_of(input logic [7:0] c);
    int h;
    h = (c[4:3] == 2'd3) ? 64 : (2 << (2 * c[4:3]));
    return c[5] ? h / 2 : h;
  endfunction

  task automatic begin_xfer(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] sv);
    logic [7:0] v;
    wr_reg(S_CTRL, c);
    rd_reg(S_STAT, v);
    b_cpol = c[1]; b_cpha = c[2]; b_h = half_of(c); slv_tx = sv;
    data_start(tx);
  endtask

  task automatic end_xfer(input logic [7:0] tx, input logic [7:0] sv, input string tag);
    logic [7:0] v;
    while (!finished) @(posedge clk);
    finished = 0;
    chk(tr_err == 0, tag, "sck/busy/done trace (R3 R5 R6)", tr_act, tr_exp);
    chk(slv_rx == tx, tag, "byte seen by slave, msb first (R1 R2 R4)", slv_rx, tx);
    peek(S_DATA, v);
    chk(v == sv, tag, "receive buffer (R1 R2)", v, sv);
  endtask

  // cycle-by-cycle model: expected sck, busy and done; slave shift behaviour
  initial begin
    int e, bi;
    bit lead;
    miso = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (pending) begin
        pending = 0; active = 1; m = 0; seen = 0; sck_prev = b_cpol;
        slv_rx = 8'h00; tr_err = 0; tr_act = 0; tr_exp = 0;
      end
      if (active) begin
        e = m / b_h;
        if (e > 16) e = 16;
        if (sck !== (b_cpol ^ e[0])) begin
          if (tr_err == 0) begin tr_act = 1000 + m * 2 + sck; tr_exp = 1000 + m * 2 + (b_cpol ^ e[0]); end
          tr_err++;
        end
        if (reg_sel == S_STAT) begin
          if (reg_rdata[2] !== (m < 16 * b_h) || reg_rdata[0] !== (m >= 16 * b_h)) begin
            if (tr_err == 0) begin tr_act = {reg_rdata[2], reg_rdata[0]}; tr_exp = {m < 16 * b_h, m >= 16 * b_h}; end
            tr_err++;
          end
        end
        if (sck !== sck_prev) begin
          seen++;
          lead = (sck != b_cpol);
          if (lead != b_cpha) slv_rx = {slv_rx[6:0], mosi};
          sck_prev = sck;
        end
        bi = b_cpha ? ((seen == 0) ? 0 : (seen - 1) / 2) : seen / 2;
        miso = (bi < 8) ? slv_tx[7 - bi] : 1'b0;
        m++;
        if (m > 16 * b_h) begin active = 0; finished = 1; end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // reset state
    peek(S_CTRL, v); chk(v == 8'h00, "R12", "control after reset", v, 0);
    peek(S_STAT, v); chk(v == 8'h00, "R12", "status after reset", v, 0);
    peek(S_DATA, v); chk(v == 8'h00, "R12", "receive buffer after reset", v, 0);
    chk(sck == 1'b0 && mosi == 1'b0, "R12", "sck/mosi after reset", {sck, mosi}, 0);

    // four clock modes, several rates
    begin_xfer(8'h01, 8'hA5, 8'h3C); end_xfer(8'hA5, 8'h3C, "R1 mode0 div4");
    begin_xfer(8'h2D, 8'h81, 8'hE7); end_xfer(8'h81, 8'hE7, "R4 mode1 div8");
    begin_xfer(8'h23, 8'h5E, 8'h91); end_xfer(8'h5E, 8'h91, "R3 mode2 div2");
    begin_xfer(8'h17, 8'hC3, 8'h0F); end_xfer(8'hC3, 8'h0F, "R5 mode3 div64");
    begin_xfer(8'h1D, 8'h6B, 8'hD2); end_xfer(8'h6B, 8'hD2, "R5 mode1 div128");
    peek(S_STAT, v); chk(v == 8'h01, "R6", "done set, busy clear", v, 1);

    // R8: data access without prior status read keeps flags
    rd_reg(S_DATA, v);
    peek(S_STAT, v); chk(v[0] == 1'b1, "R8", "done kept without status read", v[0], 1);
    rd_reg(S_STAT, v);
    rd_reg(S_DATA, v);
    peek(S_STAT, v); chk(v == 8'h00, "R8", "flags cleared by status then data", v, 0);

    // R7: collision during an exchange
    begin_xfer(8'h01, 8'h96, 8'h4B);
    repeat (10) @(posedge clk);
    wr_reg(S_DATA, 8'h11);
    peek(S_STAT, v); chk(v == 8'h06, "R7", "collision with busy", v, 6);
    end_xfer(8'h96, 8'h4B, "R7 collision");
    peek(S_STAT, v); chk(v == 8'h03, "R7", "done and collision after end", v, 3);

    // R11: previous byte readable while next one shifts
    begin_xfer(8'h09, 8'h3A, 8'hC5);
    repeat (12) @(posedge clk);
    rd_reg(S_DATA, v); chk(v == 8'h4B, "R11", "old byte during next exchange", v, 8'h4B);
    end_xfer(8'h3A, 8'hC5, "R11 next exchange");

    // R10: disabled write ignored
    wr_reg(S_CTRL, 8'h02);
    wr_reg(S_DATA, 8'h77);
    repeat (20) @(posedge clk);
    peek(S_STAT, v); chk(v[2] == 1'b0 && sck == 1'b1, "R10", "no exchange while disabled", {v[2], sck}, 1);
    peek(S_DATA, v); chk(v == 8'hC5, "R10", "buffer unchanged", v, 8'hC5);

    // R9: guarded abort
    rd_reg(S_STAT, v); rd_reg(S_DATA, v);
    wr_reg(S_CTRL, 8'h43);
    wr_reg(S_DATA, 8'h5A);
    repeat (6) @(posedge clk);
    @(negedge clk) ss_in = 1'b0;
    repeat (6) @(posedge clk);
    peek(S_CTRL, v); chk(v == 8'h42, "R9", "enable dropped", v, 8'h42);
    peek(S_STAT, v); chk(v == 8'h01, "R9", "done set, not busy", v, 1);
    repeat (40) @(posedge clk);
    chk(sck == 1'b1, "R9", "sck held idle after abort", sck, 1);
    @(negedge clk) ss_in = 1'b1;

    // R9: guard clear, ss_in ignored
    @(negedge clk) ss_in = 1'b0;
    begin_xfer(8'h01, 8'hE1, 8'h1E); end_xfer(8'hE1, 8'h1E, "R9 guard off");
    peek(S_CTRL, v); chk(v == 8'h01, "R9", "enable kept with guard off", v, 1);
    @(negedge clk) ss_in = 1'b1;

    finish_run();
  end

endmodule